// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral on a simple synchronous register bus. Software loads a timeout value and then sets the enable bit, which starts a down-counter.

The first time the counter reaches zero, the block raises a pending interrupt and reloads the counter. If software does not clear that interrupt before the counter reaches zero again, the block escalates. When reset generation is enabled, it emits a one-cycle system reset pulse.

A key-protected lock register can freeze every other register against stray writes.

The bus is a single port with a 12-bit byte address, a write strobe and 32-bit write data. Read data is combinational and follows the address in the same cycle. Register writes take effect at the clock edge on which the strobe is sampled.

Top module: `wdog_top`

## Requirements
- R1: After reset: load (offset 0x000) and value (0x004) read 0xFFFFFFFF; control (0x008), raw status (0x010), masked status (0x014) and lock (0xC00) read 0; `irq_o` and `sys_rst_o` are low.
- R2: The value register is read-only. A read of 0x004 returns the live counter. Writes to 0x004 and to unmapped offsets change nothing. Interrupt-clear (0x00C) and unmapped offsets read 0.
- R3: While control bit 0 (enable) is set, the counter drops by one each cycle. While enable is clear, the counter holds its value.
- R4: When the counter is at zero in an enabled cycle and no interrupt is pending, status bit 0 becomes set and the counter reloads from the load register. A running watchdog therefore times out every load+1 cycles.
- R5: When the counter is at zero with the interrupt already pending, the counter reloads and the interrupt stays pending. `sys_rst_o` pulses high for exactly one cycle if control bit 1 (reset enable) is set. If bit 1 is clear, `sys_rst_o` stays low.
- R6: A write of any data to 0x00C clears the pending interrupt and reloads the counter from the load register. This clear takes priority over a timeout in the same cycle.
- R7: A load write while enabled places the written value in the counter on the next cycle and leaves a pending interrupt untouched. A load write while disabled updates only the load register.
- R8: Writing control with bit 0 set starts the watchdog and preloads the counter from the load register. Once bit 0 is set, further control writes are ignored, and only reset clears the bit.
- R9: Masked status bit 0 equals raw status AND enable, and `irq_o` equals masked status.
- R10: Writing 0x1ACCE551 to 0xC00 unlocks; writing any other value locks. 0xC00 reads 1 while locked. While locked, writes to all other registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Watchdog interrupt (masked status) |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach is the second timeout with the interrupt still pending. It takes a running counter, the reset-enable bit set before the enable bit closes the control register, and no clear for a whole period.

Directed steps set reset enable together with enable, use a short load value, and then idle across two periods.

Randomised sessions with load values of 0 to 15 and sparse clear writes race clears against timeouts many times. These sessions include load 0, where the counter sits at zero every cycle.

A second random session with reset enable clear confirms that escalation stays silent.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_LOAD  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_VALUE = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_ICR   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_RIS   = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_MIS   = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_LOCK  = 12'hC00;

  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_RST_BIT = 1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LOAD, SEL_VALUE, SEL_CTRL,
    SEL_ICR, SEL_RIS, SEL_MIS, SEL_LOCK
  } reg_sel_e;

  typedef struct packed {
    logic start;    // enable bit newly set
    logic load_wr;  // accepted load-register write
    logic clr;      // accepted interrupt-clear write
  } cnt_cmd_t;
endpackage

// File: rtl/wdog_decode.sv
module wdog_decode
  import wdog_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    case (addr_i)
      OFF_LOAD:  sel_o = SEL_LOAD;
      OFF_VALUE: sel_o = SEL_VALUE;
      OFF_CTRL:  sel_o = SEL_CTRL;
      OFF_ICR:   sel_o = SEL_ICR;
      OFF_RIS:   sel_o = SEL_RIS;
      OFF_MIS:   sel_o = SEL_MIS;
      OFF_LOCK:  sel_o = SEL_LOCK;
      default:   sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/wdog_lock.sv
module wdog_lock
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          locked_o
);
  localparam logic [DW-1:0] KEY = DW'(UNLOCK_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   locked_o <= 1'b0;
    else if (wr_i) locked_o <= (wdata_i != KEY);
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  reg_sel_e      sel_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          locked_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          ris_i,
  output logic [DW-1:0] load_o,
  output logic          en_o,
  output logic          rst_en_o,
  output cnt_cmd_t      cmd_o,
  output logic [DW-1:0] rdata_o
);
  logic wr_ok, load_wr, ctrl_wr, mis;

  assign wr_ok   = wr_en_i && !locked_i;
  assign load_wr = wr_ok && (sel_i == SEL_LOAD);
  // control freezes once enable is set
  assign ctrl_wr = wr_ok && (sel_i == SEL_CTRL) && !en_o;
  assign mis     = ris_i && en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      load_o <= '1;
    else if (load_wr) load_o <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      rst_en_o <= 1'b0;
    end else if (ctrl_wr) begin
      en_o     <= wdata_i[CTRL_EN_BIT];
      rst_en_o <= wdata_i[CTRL_RST_BIT];
    end
  end

  always_comb begin
    cmd_o.start   = ctrl_wr && wdata_i[CTRL_EN_BIT];
    cmd_o.load_wr = load_wr;
    cmd_o.clr     = wr_ok && (sel_i == SEL_ICR);
  end

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SEL_LOAD:  rdata_o = load_o;
      SEL_VALUE: rdata_o = cnt_i;
      SEL_CTRL: begin
        rdata_o[CTRL_EN_BIT]  = en_o;
        rdata_o[CTRL_RST_BIT] = rst_en_o;
      end
      SEL_RIS:  rdata_o[0] = ris_i;
      SEL_MIS:  rdata_o[0] = mis;
      SEL_LOCK: rdata_o[0] = locked_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          rst_en_i,
  input  cnt_cmd_t      cmd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] load_i,
  output logic [DW-1:0] cnt_o,
  output logic          ris_o,
  output logic          rst_pulse_o
);
  logic at_zero;
  assign at_zero = (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o       <= '1;
      ris_o       <= 1'b0;
      rst_pulse_o <= 1'b0;
    end else begin
      rst_pulse_o <= 1'b0;
      if (cmd_i.clr) ris_o <= 1'b0;
      if (cmd_i.start) begin
        cnt_o <= load_i;
      end else if (en_i) begin
        if (cmd_i.clr) begin
          cnt_o <= load_i;
        end else if (cmd_i.load_wr) begin
          cnt_o <= wdata_i;
        end else if (at_zero) begin
          cnt_o <= load_i;
          if (ris_o) rst_pulse_o <= rst_en_i;
          else       ris_o       <= 1'b1;
        end else begin
          cnt_o <= cnt_o - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);
  reg_sel_e      sel;
  cnt_cmd_t      cmd;
  logic          locked, inten, resen, ris;
  logic [DW-1:0] load_q, cnt;

  wdog_decode u_decode (.addr_i(addr_i), .sel_o(sel));

  wdog_lock #(.DW(DW)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr_en_i && (sel == SEL_LOCK)),
    .wdata_i(wdata_i), .locked_o(locked)
  );

  wdog_regs #(.DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .locked_i(locked), .cnt_i(cnt), .ris_i(ris),
    .load_o(load_q), .en_o(inten), .rst_en_o(resen), .cmd_o(cmd),
    .rdata_o(rdata_o)
  );

  wdog_counter #(.DW(DW)) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(inten), .rst_en_i(resen),
    .cmd_i(cmd), .wdata_i(wdata_i), .load_i(load_q), .cnt_o(cnt),
    .ris_o(ris), .rst_pulse_o(sys_rst_o)
  );

  assign irq_o = ris && inten;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DW-1:0]     wdata_i,
  input logic              irq_o,
  input logic              sys_rst_o,
  input logic              inten,
  input logic              ris,
  input logic              locked,
  input logic [DW-1:0]     cnt,
  input logic [DW-1:0]     load_q
);
  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inten && !wr_en_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  p_rst_needs_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> ris);

  p_rst_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_o && load_q != '0) |=> !sys_rst_o);

  p_clear_only_by_icr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ris) |-> $past(wr_en_i && addr_i == OFF_ICR && !locked));

  p_load_immediate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inten && !locked && wr_en_i && addr_i == OFF_LOAD) |=> (cnt == $past(wdata_i)));

  p_enable_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inten |=> inten);

  p_irq_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inten |-> !irq_o);

  p_locked_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && wr_en_i && addr_i == OFF_LOAD) |=> $stable(load_q));
endmodule

bind wdog_top wdog_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .sys_rst_o(sys_rst_o), .inten(inten),
  .ris(ris), .locked(locked), .cnt(cnt), .load_q(load_q)
);

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;
  import wdog_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, srst;

  int checks = 0, fails = 0, rst_seen = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_load, m_cnt;
  bit m_en, m_resen, m_ris, m_lock, m_rst;

  always #4 clk = ~clk;  // 125 MHz

  wdog_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .sys_rst_o(srst)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [11:0] a);
    case (a)
      OFF_LOAD:  return m_load;
      OFF_VALUE: return m_cnt;
      OFF_CTRL:  return {30'd0, m_resen, m_en};
      OFF_RIS:   return {31'd0, m_ris};
      OFF_MIS:   return {31'd0, m_ris & m_en};
      OFF_LOCK:  return {31'd0, m_lock};
      default:   return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_load = '1; m_cnt = '1; m_en = 0; m_resen = 0;
    m_ris = 0; m_lock = 0; m_rst = 0;
  endtask

  task automatic do_reset();
    we = 0; addr = '0; wdata = '0;
    rst_n = 0;
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  // one bus cycle; read data is checked before the edge, outputs after it
  task automatic step(bit w, logic [11:0] a, logic [31:0] d, string tag);
    logic [31:0] n_load, n_cnt;
    bit n_en, n_resen, n_ris, n_lock, n_rst, ok, start, ldw, clr;
    we = w; addr = a; wdata = d;
    #1;
    if (!w) chk(tag, rdata, exp_read(a));
    n_load = m_load; n_cnt = m_cnt; n_en = m_en; n_resen = m_resen;
    n_ris = m_ris; n_lock = m_lock; n_rst = 0;
    ok    = w && !m_lock;
    ldw   = ok && a == OFF_LOAD;
    clr   = ok && a == OFF_ICR;
    start = ok && a == OFF_CTRL && !m_en && d[0];
    if (w && a == OFF_LOCK) n_lock = (d != UNLOCK_KEY);
    if (ldw) n_load = d;
    if (ok && a == OFF_CTRL && !m_en) begin n_en = d[0]; n_resen = d[1]; end
    if (clr) n_ris = 0;
    if (start) n_cnt = m_load;
    else if (m_en) begin
      if (clr) n_cnt = m_load;
      else if (ldw) n_cnt = d;
      else if (m_cnt == 0) begin
        n_cnt = m_load;
        if (m_ris) n_rst = m_resen; else n_ris = 1;
      end else n_cnt = m_cnt - 1;
    end
    @(posedge clk);
    @(negedge clk);
    m_load = n_load; m_cnt = n_cnt; m_en = n_en; m_resen = n_resen;
    m_ris = n_ris; m_lock = n_lock; m_rst = n_rst;
    chk("R9 irq_o", {31'd0, irq}, {31'd0, m_ris & m_en});
    chk("R5 sys_rst_o", {31'd0, srst}, {31'd0, m_rst});
    if (srst) rst_seen++;
  endtask

  task automatic rd(logic [11:0] a, string tag);
    step(0, a, 32'd0, tag);
  endtask

  function automatic logic [11:0] pick_addr(int k);
    case (k)
      0: return OFF_LOAD;  1: return OFF_VALUE; 2: return OFF_CTRL;
      3: return OFF_ICR;   4: return OFF_RIS;   5: return OFF_MIS;
      6: return OFF_LOCK;  default: return 12'h020;
    endcase
  endfunction

  task automatic random_phase(int n);
    for (int i = 0; i < n; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 55)      rd(pick_addr($urandom_range(0, 7)), "R2 random read");
      else if (r < 70) step(1, OFF_LOAD, $urandom_range(0, 15), "R7");
      else if (r < 76) step(1, OFF_ICR, $urandom, "R6");
      else if (r < 81) step(1, OFF_CTRL, $urandom, "R8");
      else if (r < 86) step(1, OFF_VALUE, $urandom, "R2");
      else if (r < 93) step(1, OFF_LOCK, ($urandom_range(0, 1) != 0) ? UNLOCK_KEY : $urandom, "R10");
      else             step(1, 12'h7F0, $urandom, "R2 unmapped");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(OFF_LOAD, "R1"); rd(OFF_VALUE, "R1"); rd(OFF_CTRL, "R1");
    rd(OFF_RIS, "R1");  rd(OFF_MIS, "R1");   rd(OFF_LOCK, "R1");
    chk("R1 irq_o", {31'd0, irq}, 32'd0);

    // R7 disabled load write leaves counter; R3 counter frozen
    step(1, OFF_LOAD, 32'd7, "R7");
    rd(OFF_VALUE, "R7 disabled");
    rd(OFF_VALUE, "R3 frozen");
    chk("R3 value frozen", m_cnt, 32'hFFFF_FFFF);

    // R10 lock blocks writes
    step(1, OFF_LOCK, 32'h5, "R10");
    rd(OFF_LOCK, "R10 locked reads 1");
    step(1, OFF_LOAD, 32'd3, "R10");
    rd(OFF_LOAD, "R10 load ignored");
    step(1, OFF_LOCK, UNLOCK_KEY, "R10");
    rd(OFF_LOCK, "R10 unlocked");

    // R2 value is read-only; unmapped and clear read 0
    step(1, OFF_VALUE, 32'd2, "R2");
    rd(OFF_VALUE, "R2 value unchanged");
    rd(OFF_ICR, "R2 clear reads 0");

    // R8 start with preload, reset enable on
    step(1, OFF_CTRL, 32'h3, "R8");
    chk("R8 preload", m_cnt, 32'd7);
    rd(OFF_VALUE, "R8 preload value");
    rd(OFF_VALUE, "R3 decrement");
    step(1, OFF_CTRL, 32'h0, "R8");
    rd(OFF_CTRL, "R8 control locked");

    // R4 first timeout
    while (!m_ris) rd(OFF_VALUE, "R4 count");
    rd(OFF_RIS, "R4 raw set");
    rd(OFF_MIS, "R9 masked");
    // R6 clear, R7 load write does not clear
    step(1, OFF_ICR, 32'hDEAD, "R6");
    rd(OFF_RIS, "R6 cleared");
    while (!m_ris) rd(OFF_VALUE, "R4 count");
    step(1, OFF_LOAD, 32'd4, "R7");
    rd(OFF_VALUE, "R7 immediate");
    rd(OFF_RIS, "R7 pending kept");
    // R5 escalation
    while (!m_rst) rd(OFF_RIS, "R5 wait");
    chk("R5 pulse seen", (rst_seen > 0) ? 32'd1 : 32'd0, 32'd1);
    rd(OFF_RIS, "R5 still pending");

    random_phase(4000);

    // second session: reset enable off
    do_reset();
    step(1, OFF_LOAD, 32'd2, "R7");
    step(1, OFF_CTRL, 32'h1, "R8");
    rst_seen = 0;
    for (int i = 0; i < 12; i++) rd(OFF_RIS, "R5 no reset");
    chk("R5 silent", rst_seen, 32'd0);
    random_phase(4000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule